// File: doc/BRIEF.md
# Thermal Per-Rank Bandwidth Throttler

This block caps the number of memory transactions that each of several DRAM ranks may accept within a repeating time window. One window timer, shared by all ranks, counts controller clock cycles up to a programmable length. Each rank has its own counter of issued transactions. The counter is compared against a limit, and the limit is chosen from the rank's live thermal state: a warm limit, a hot limit, or no limit at all when the rank is cool. When a rank has used its allowance, a registered block flag tells the scheduler to stop sending it work until the window rolls over.

Settings arrive as one 32-bit configuration word with a write strobe. The two limit fields may be rewritten at any moment. The window-length field is locked while the throttler is enabled, so the enable input must be dropped to retime the window. When the block is disabled, every rank is released and all counting state is held clear.

Top module: `thermal_bw_throttle`

## Requirements
- R1: After reset, every block flag is 0. The configuration resets to hot limit 255, warm limit 255 and a window of 1023 cycles.
- R2: A write puts configuration bits [31:24] into the hot limit and bits [23:16] into the warm limit at any time. The block flags use the new limits from the same clock edge that captures the write. Bits [15:10] are not stored.
- R3: Configuration bits [9:0] set the window length in cycles. A write to this field is ignored while enable is high, and a value of 0 is never accepted.
- R4: Thermal code per rank is 2 bits: 00 cool, 01 warm, 10 or 11 hot. A cool rank's block flag is 0 on the next clock edge, whatever its count.
- R5: Each rank counts its issue pulses, and the counter saturates at 255. The block flag becomes 1 on the clock edge that brings the count to or above the limit for the rank's current state.
- R6: With enable high, the window repeats every N cycles, where N is the programmed length. On the edge that ends a window, all rank counters clear and an issue pulse in that final cycle is dropped.
- R7: A limit of 0 holds a warm or hot rank blocked for the whole window.
- R8: When a rank's thermal state changes mid-window, the count it has already reached is kept, and the limit for the new state applies from the next clock edge.
- R9: While enable is low, every block flag is 0 and the window and rank counters are held at 0. The first enabled cycle starts a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock that times the window |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Throttling active; low unlocks the window length |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| rank_temp | input | 2*NUM_RANKS | Thermal code per rank, rank r at bits [2r+1:2r] |
| rank_issue | input | NUM_RANKS | One-cycle pulse per transaction sent to a rank |
| rank_block | output | NUM_RANKS | Hold back further transactions to the rank |

## Verification
Two events can fall in the same cycle: the end-of-window clear and an issue pulse, and, separately, a limit or thermal change and a counter increment. The bench provokes the first by holding the issue pulses high across several window boundaries with short windows, including a window length rewritten while enabled that must have no effect. It provokes the second by rewriting limits and changing thermal codes during random traffic. A behavioural model built on integers predicts every block flag, and the flags are compared against it after each clock edge.

// File: rtl/thermal_bw_pkg.sv
package thermal_bw_pkg;

  localparam int LIM_W = 8;
  localparam int WIN_W = 10;

  typedef enum logic [1:0] {
    TEMP_COOL    = 2'b00,
    TEMP_WARM    = 2'b01,
    TEMP_HOT     = 2'b10,
    TEMP_HOT_ALT = 2'b11
  } temp_e;

  typedef struct packed {
    logic [LIM_W-1:0] hot_lim;
    logic [LIM_W-1:0] warm_lim;
    logic [WIN_W-1:0] win_len;
  } thr_cfg_t;

  localparam thr_cfg_t CFG_RESET = '{hot_lim: 8'hFF, warm_lim: 8'hFF, win_len: 10'h3FF};

endpackage

// File: rtl/thermal_cfg_reg.sv
module thermal_cfg_reg
  import thermal_bw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output thr_cfg_t    cfg_q,
  output thr_cfg_t    cfg_nxt
);

  logic [WIN_W-1:0] wr_len;
  logic             len_ok;
  logic             cfg_en;

  assign wr_len = cfg_wdata[WIN_W-1:0];
  assign len_ok = !enable && (wr_len != '0);
  assign cfg_en = cfg_wr;

  always_comb begin
    cfg_nxt = cfg_q;
    if (cfg_wr) begin
      cfg_nxt.hot_lim  = cfg_wdata[31:24];
      cfg_nxt.warm_lim = cfg_wdata[23:16];
      if (len_ok) begin
        cfg_nxt.win_len = wr_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_en) begin
      cfg_q <= cfg_nxt;
    end
  end

endmodule

// File: rtl/thermal_win_timer.sv
module thermal_win_timer #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [WIN_W-1:0] win_len,
  output logic [WIN_W-1:0] win_cnt,
  output logic             win_wrap
);

  logic [WIN_W-1:0] win_last;
  logic [WIN_W-1:0] win_cnt_nxt;
  logic             win_en;

  assign win_last = win_len - WIN_W'(1);
  assign win_wrap = enable && (win_cnt == win_last);

  always_comb begin
    if (!enable || win_wrap) begin
      win_cnt_nxt = '0;
    end else begin
      win_cnt_nxt = win_cnt + WIN_W'(1);
    end
  end

  assign win_en = enable || (win_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (win_en) begin
      win_cnt <= win_cnt_nxt;
    end
  end

endmodule

// File: rtl/thermal_rank_gate.sv
module thermal_rank_gate
  import thermal_bw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             win_clear,
  input  logic             issue,
  input  logic [1:0]       temp,
  input  logic [CNT_W-1:0] hot_lim,
  input  logic [CNT_W-1:0] warm_lim,
  output logic [CNT_W-1:0] cnt,
  output logic             block
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  temp_e            temp_s;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] lim_sel;
  logic             block_nxt;
  logic             cnt_en;

  assign temp_s = temp_e'(temp);

  always_comb begin
    if (!enable || win_clear) begin
      cnt_nxt = '0;
    end else if (issue && (cnt != CNT_MAX)) begin
      cnt_nxt = cnt + CNT_W'(1);
    end else begin
      cnt_nxt = cnt;
    end
  end

  always_comb begin
    unique case (temp_s)
      TEMP_WARM:             lim_sel = warm_lim;
      TEMP_HOT, TEMP_HOT_ALT: lim_sel = hot_lim;
      default:               lim_sel = CNT_MAX;
    endcase
  end

  assign block_nxt = enable && (temp_s != TEMP_COOL) && (cnt_nxt >= lim_sel);
  assign cnt_en    = (cnt_nxt != cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      block <= 1'b0;
    end else begin
      block <= block_nxt;
    end
  end

endmodule

// File: rtl/thermal_bw_throttle.sv
module thermal_bw_throttle
  import thermal_bw_pkg::*;
#(
  parameter int NUM_RANKS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   cfg_wr,
  input  logic [31:0]            cfg_wdata,
  input  logic [2*NUM_RANKS-1:0] rank_temp,
  input  logic [NUM_RANKS-1:0]   rank_issue,
  output logic [NUM_RANKS-1:0]   rank_block
);

  thr_cfg_t                     cfg_q;
  thr_cfg_t                     cfg_nxt;
  logic [WIN_W-1:0]             win_len;
  logic [WIN_W-1:0]             win_cnt;
  logic                         win_wrap;
  logic [NUM_RANKS*LIM_W-1:0]   rank_cnt;

  thermal_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .cfg_nxt   (cfg_nxt)
  );

  assign win_len = cfg_q.win_len;

  thermal_win_timer #(.WIN_W(WIN_W)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .win_len  (win_len),
    .win_cnt  (win_cnt),
    .win_wrap (win_wrap)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    thermal_rank_gate #(.CNT_W(LIM_W)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .win_clear (win_wrap),
      .issue     (rank_issue[r]),
      .temp      (rank_temp[2*r +: 2]),
      .hot_lim   (cfg_nxt.hot_lim),
      .warm_lim  (cfg_nxt.warm_lim),
      .cnt       (rank_cnt[r*LIM_W +: LIM_W]),
      .block     (rank_block[r])
    );
  end

endmodule

// File: rtl/thermal_bw_throttle_chk.sv
module thermal_bw_throttle_chk #(
  parameter int NUM_RANKS = 4,
  parameter int LIM_W     = 8,
  parameter int WIN_W     = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enable,
  input logic [2*NUM_RANKS-1:0] rank_temp,
  input logic [NUM_RANKS-1:0]   rank_issue,
  input logic [NUM_RANKS-1:0]   rank_block,
  input logic [WIN_W-1:0]       win_cnt,
  input logic [WIN_W-1:0]       win_len,
  input logic                   win_wrap,
  input logic [NUM_RANKS*LIM_W-1:0] rank_cnt
);

  // R9
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (rank_block == '0));

  // R6
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt < win_len);

  // R3
  win_len_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(win_len));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    // R4
    cool_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rank_temp[2*r +: 2] == 2'b00) |=> !rank_block[r]);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && rank_issue[r] && !win_wrap && (rank_cnt[r*LIM_W +: LIM_W] != '1))
      |=> (rank_cnt[r*LIM_W +: LIM_W] == $past(rank_cnt[r*LIM_W +: LIM_W]) + LIM_W'(1)));

    // R6
    wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_wrap |=> (rank_cnt[r*LIM_W +: LIM_W] == '0));
  end

endmodule

bind thermal_bw_throttle thermal_bw_throttle_chk #(
  .NUM_RANKS (NUM_RANKS),
  .LIM_W     (thermal_bw_pkg::LIM_W),
  .WIN_W     (thermal_bw_pkg::WIN_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .rank_temp  (rank_temp),
  .rank_issue (rank_issue),
  .rank_block (rank_block),
  .win_cnt    (win_cnt),
  .win_len    (win_len),
  .win_wrap   (win_wrap),
  .rank_cnt   (rank_cnt)
);

// File: tb/thermal_bw_throttle_tb.sv
`timescale 1ns/1ps
module thermal_bw_throttle_tb;

  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic          cfg_wr;
  logic [31:0]   cfg_wdata;
  logic [2*NR-1:0] rank_temp;
  logic [NR-1:0] rank_issue;
  logic [NR-1:0] rank_block;

  int    n_chk  = 0;
  int    n_fail = 0;
  string tag    = "R1";
  bit    done   = 1'b0;

  // behavioural reference state
  int m_hot, m_warm, m_len, m_win;
  int m_cnt [NR];
  bit [NR-1:0] m_blk;

  always #2 clk = ~clk;

  thermal_bw_throttle #(.NUM_RANKS(NR)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .rank_temp  (rank_temp),
    .rank_issue (rank_issue),
    .rank_block (rank_block)
  );

  task automatic check(input bit ok, input string req, input logic [NR-1:0] act, input logic [NR-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: rank_block=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hot = 255; m_warm = 255; m_len = 1023; m_win = 0; m_blk = '0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      bit wrap;
      wrap = enable && (m_win == m_len - 1);
      if (cfg_wr) begin
        m_hot  = cfg_wdata[31:24];
        m_warm = cfg_wdata[23:16];
      end
      if (!enable) begin
        m_win = 0; m_blk = '0;
        foreach (m_cnt[i]) m_cnt[i] = 0;
      end else begin
        m_win = wrap ? 0 : m_win + 1;
        for (int r = 0; r < NR; r++) begin
          int t, lim;
          if (wrap) m_cnt[r] = 0;
          else if (rank_issue[r] && m_cnt[r] < 255) m_cnt[r]++;
          t   = rank_temp[2*r +: 2];
          lim = (t == 1) ? m_warm : m_hot;
          m_blk[r] = (t != 0) && (m_cnt[r] >= lim);
        end
      end
      if (cfg_wr && !enable && cfg_wdata[9:0] != 0) m_len = cfg_wdata[9:0];
      #1;
      if (!done) check(rank_block === m_blk, tag, rank_block, m_blk);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input int hot, input int warm, input int len);
    cfg_wr    = 1'b1;
    cfg_wdata = {hot[7:0], warm[7:0], 6'h3F, len[9:0]};
    step(1);
    cfg_wr    = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    rank_temp = '0; rank_issue = '0;
    step(3);
    check(rank_block === '0, "R1", rank_block, '0);
    rst_n = 1'b1;
    // R1: defaults never limit a short burst
    tag = "R1"; enable = 1'b1; rank_temp = 8'b10_10_01_01; rank_issue = '1;
    step(20);
    enable = 1'b0; rank_issue = '0; step(2);
    // R2, R4, R5, R6: hot 3, warm 5, window 20, constant traffic across wraps
    tag = "R2"; write_cfg(3, 5, 20);
    tag = "R5"; enable = 1'b1;
    rank_temp = {2'b10, 2'b11, 2'b01, 2'b00}; rank_issue = '1;
    step(25);
    tag = "R6"; step(45);
    tag = "R4"; rank_temp[1:0] = 2'b00; step(5);
    // R8: state change mid-window keeps count
    tag = "R8"; rank_issue = '0; step(3);
    rank_issue = 4'b0010; step(4);
    rank_temp[3:2] = 2'b10; step(3);
    rank_temp[3:2] = 2'b01; step(3);
    rank_temp[3:2] = 2'b00; step(3);
    rank_temp[3:2] = 2'b11; step(6);
    // R3: window rewrite while enabled is ignored, limits still land (R2)
    tag = "R3"; rank_issue = '1; write_cfg(1, 2, 7);
    for (int i = 0; i < 60; i++) begin
      rank_issue = 4'($urandom);
      step(1);
    end
    // R7: zero hot limit blocks for whole window
    tag = "R7"; write_cfg(0, 2, 7);
    rank_temp = {2'b10, 2'b10, 2'b01, 2'b11}; rank_issue = '0;
    step(45);
    // R9: disabled releases all and holds clear
    tag = "R9"; enable = 1'b0; rank_issue = '1; step(6);
    write_cfg(4, 6, 0);
    write_cfg(4, 6, 9);
    enable = 1'b1;
    for (int i = 0; i < 200; i++) begin
      rank_issue = 4'($urandom);
      if ((i % 13) == 0) rank_temp = 8'($urandom);
      if ((i % 37) == 5) begin
        tag = "R2";
        cfg_wr = 1'b1;
        cfg_wdata = {8'($urandom_range(0, 6)), 8'($urandom_range(0, 6)), 16'h0009};
      end else begin
        cfg_wr = 1'b0;
      end
      step(1);
    end
    cfg_wr = 1'b0;
    // R5: saturation at 255 within a long window
    tag = "R5"; enable = 1'b0; step(1);
    write_cfg(255, 255, 600);
    enable = 1'b1; rank_temp = {2'b01, 2'b01, 2'b10, 2'b00}; rank_issue = '1;
    step(300);
    rank_issue = '0; step(10);
    done = 1'b1;
    step(2);
    summary();
  end

endmodule